// File: doc/BRIEF.md
# Byte-Lane Sequencer for Asynchronous Static RAM

This block sits between a clocked on-chip client and an external asynchronous static RAM with a 16-bit data word split into two byte lanes and an 18-bit word address. The client hands over one word access at a time through a valid/ready handshake. The block then lays out the memory pin activity over a fixed number of system clock cycles. Each access has three parts. A setup cycle moves the address while every strobe is inactive. The active phase follows, with chip enable, output enable and the selected lane enables held low, and write enable also held low for a write. A recovery cycle ends the access with every strobe inactive again.

The data bus appears as three signals: an outgoing word, an incoming word and a drive enable. A write keeps output enable low and raises the drive enable only in the final cycles of its write-enable pulse. The opening cycles of the pulse give the memory time to release the bus before the block drives it. The phase lengths come from nanosecond timing parameters and the clock period, rounded up to whole cycles. A request whose byte mask selects no lane completes at once and leaves every memory pin untouched.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, rsp_valid is 0, the drive enable is 0, and chip enable, output enable, write enable and both lane enables are all high.
- R2: mem_addr changes only on a clock edge where chip enable, write enable and both lane enables are high in the cycle before and in the cycle after.
- R3: A read with a non-zero mask holds chip enable and output enable low and write enable high for 6 cycles. It then gives exactly one rsp_valid pulse. rsp_rdata carries the memory word on the enabled lanes and zero on the disabled lanes.
- R4: A write with a non-zero mask holds chip enable, write enable and output enable low for 6 cycles. Afterwards the memory holds the new data on the enabled lanes and its old data on the other lane.
- R5: The data bus is driven only while write enable is low. Drive starts 3 cycles before the end of the write pulse and lasts until write enable rises, with mem_dq_out equal to the request data. The block never drives while the memory is in read mode.
- R6: Each fall of chip enable follows a cycle in which all control lines were high. Back-to-back accesses therefore always have an idle cycle between them.
- R7: A request with mask 00 moves no memory pin and keeps req_ready high. A null write changes no stored data. A null read gives rsp_valid in the next cycle with rsp_rdata equal to 0.
- R8: req_ready is low from the cycle after a non-null request is accepted until the access has finished (8 cycles). A request presented while req_ready is low is ignored.
- R9: rsp_valid is a single-cycle pulse and never occurs for a write.
- R10: Mask bit 0 selects the low lane (data bits 7:0, mem_lane_n[0]) and mask bit 1 selects the high lane (bits 15:8, mem_lane_n[1]). A lane enable goes low only during the active phase of an access whose mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | Read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | 2 | Lane enables, active low, bit 0 low byte |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_in | input | 16 | Data returned by the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
Two things can fall in the same cycle: the response of a null read and the acceptance of the next request, because req_ready never drops for a mask of 00. The bench issues a null read and presents a full write in the very cycle that the zero-valued rsp_valid pulse appears. It then checks that the pulse carries 0 and that the write still runs its full 6-cycle pulse. A second overlap sits on the bus: the memory's read drivers turning off and the block's write drive turning on. A behavioural memory in the bench counts any cycle where both sides drive, and any address move under an active strobe.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_GAP    = 2'd3
  } seq_state_t;

  // Whole clock cycles needed to cover a nanosecond figure (rounded up).
  function automatic int unsigned cycles_of(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // True in the trailing drv cycles of a len-cycle phase.
  function automatic logic in_drive_window(input int unsigned cnt, input int unsigned len,
                                           input int unsigned drv);
    return (cnt + drv) >= len;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt,
  output logic          last
);

  assign last = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!last)     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sram_seq_lanes.sv
module sram_seq_lanes #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic [LANES-1:0] lane_en,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout
);

  logic [LANE_W-1:0] cap [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)      cap[g] <= '0;
      else if (sample) cap[g] <= lane_en[g] ? din[g*LANE_W +: LANE_W] : '0;
    end
    assign dout[g*LANE_W +: LANE_W] = cap[g];
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl #(
  parameter int ADDR_W  = 18,
  parameter int LANES   = 2,
  parameter int LANE_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 55,
  parameter int T_WC_NS = 55,
  parameter int T_WP_NS = 45,
  parameter int T_DW_NS = 25,
  localparam int DW     = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_lane_n,
  output logic [DW-1:0]     mem_dq_out,
  input  logic [DW-1:0]     mem_dq_in,
  output logic              mem_dq_oe
);
  import sram_seq_pkg::*;

  localparam int unsigned RD_CYC  = cycles_of(T_RC_NS, CLK_NS);
  localparam int unsigned WR_CYC  = max_of(cycles_of(T_WC_NS, CLK_NS), cycles_of(T_WP_NS, CLK_NS));
  localparam int unsigned DRV_CYC = cycles_of(T_DW_NS, CLK_NS);
  localparam int unsigned MAX_CYC = max_of(RD_CYC, WR_CYC);
  localparam int CW = $clog2(MAX_CYC + 1);

  seq_state_t          state;
  logic [ADDR_W-1:0]   lat_addr;
  logic [DW-1:0]       lat_wdata;
  logic [LANES-1:0]    lat_mask;
  logic                lat_wr;
  logic [CW-1:0]       cnt;
  logic [CW-1:0]       limit;

  // Named events for the assertions.
  logic accept, acc_null, acc_real, active, phase_last, sample_rd, ctl_off;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign acc_null   = accept && (req_mask == '0);
  assign acc_real   = accept && (req_mask != '0);
  assign active     = (state == ST_ACCESS);
  assign limit      = lat_wr ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);
  assign sample_rd  = (active && phase_last && !lat_wr) || (acc_null && !req_write);

  sram_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(active), .limit(limit), .cnt(cnt), .last(phase_last)
  );

  sram_seq_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk(clk), .rst_n(rst_n), .sample(sample_rd),
    .lane_en(req_ready ? req_mask : lat_mask),
    .din(mem_dq_in), .dout(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_mask  <= '0;
      lat_wr    <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= sample_rd;
      unique case (state)
        ST_IDLE: if (acc_real) begin
          lat_addr  <= req_addr;
          lat_wdata <= req_wdata;
          lat_mask  <= req_mask;
          lat_wr    <= req_write;
          state     <= ST_SETUP;
        end
        ST_SETUP:  state <= ST_ACCESS;
        ST_ACCESS: if (phase_last) state <= ST_GAP;
        ST_GAP:    state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr   = lat_addr;
  assign mem_dq_out = lat_wdata;
  assign mem_ce_n   = !active;
  assign mem_oe_n   = !active;
  assign mem_we_n   = !(active && lat_wr);
  assign mem_lane_n = active ? ~lat_mask : '1;
  assign mem_dq_oe  = active && lat_wr && in_drive_window(int'(cnt), WR_CYC, DRV_CYC);
  assign ctl_off    = mem_ce_n && mem_we_n && (&mem_lane_n);

  // R2: the address moves only with every strobe inactive on both sides of the edge
  a_r2_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> (ctl_off && $past(ctl_off)));

  // R5: drive only under a low write enable, and the pulse ends with data on the bus
  a_r5_drive_in_we: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_ce_n));
  a_r5_data_at_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $past(mem_dq_oe));

  // R6: a fresh selection is preceded by an all-idle cycle
  a_r6_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> $past(ctl_off && mem_oe_n));

  // R7: a null request leaves the pins idle and the handshake open
  a_r7_null_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    acc_null |=> (mem_ce_n && req_ready));

  // R8: busy after a real acceptance
  a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acc_real |=> !req_ready);

  // R9: response strobe lasts one cycle
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10: a selected chip always has at least one lane open
  a_r10_lane_open: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> (mem_lane_n != '1));

endmodule

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;

  localparam int RD_N  = (55 + 9) / 10;   // read hold cycles
  localparam int WR_N  = (55 + 9) / 10;   // write pulse cycles
  localparam int DRV_N = (25 + 9) / 10;   // trailing drive cycles
  localparam int BUSY_N = RD_N + 2;       // setup + active + recovery

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'hEEEE;

  sram_seq_ctrl u_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural memory ----------------
  logic [15:0] store  [int];
  logic [15:0] shadow [int];
  int addr_viol = 0, gap_viol = 0, clash = 0;
  bit prev_off = 1'b1, prev_ce = 1'b1;
  logic [17:0] prev_addr = '0;

  function automatic logic [15:0] rd_store(input int a);
    return store.exists(a) ? store[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] rd_shadow(input int a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit off = mem_ce_n && mem_we_n && (&mem_lane_n);
      automatic bit rd  = !mem_ce_n && !mem_oe_n && mem_we_n;
      automatic bit wr  = !mem_ce_n && !mem_we_n;
      automatic logic [15:0] cur = rd_store(int'(mem_addr));
      automatic logic [15:0] nx  = 16'hEEEE;
      if (mem_addr != prev_addr && !(off && prev_off)) addr_viol++;
      if (!mem_ce_n && prev_ce && !prev_off) gap_viol++;
      if (!mem_ce_n && prev_ce && !(mem_oe_n === 1'b0) && 1'b0) gap_viol++;
      if (rd && !mem_lane_n[0]) nx[7:0]  = cur[7:0];
      if (rd && !mem_lane_n[1]) nx[15:8] = cur[15:8];
      if (mem_dq_oe && rd && (mem_lane_n != 2'b11)) clash++;
      if (wr && mem_dq_oe) begin
        if (!mem_lane_n[0]) cur[7:0]  = mem_dq_out[7:0];
        if (!mem_lane_n[1]) cur[15:8] = mem_dq_out[15:8];
        store[int'(mem_addr)] = cur;
      end
      mem_dq_in <= nx;
      prev_off  = off && mem_oe_n;
      prev_ce   = mem_ce_n;
      prev_addr = mem_addr;
    end
  end

  // ---------------- access monitor ----------------
  int m_busy, m_ce, m_oe, m_we, m_drv, m_drv_bad, m_lane_bad, m_rsp, m_pins;
  logic [15:0] m_data;
  logic [15:0] m_wdata;
  logic [1:0]  m_mask;
  logic [37:0] snap;

  function automatic logic [37:0] pins();
    return {mem_addr, mem_ce_n, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe, 15'd0};
  endfunction

  task automatic monitor();
    m_busy = 0; m_ce = 0; m_oe = 0; m_we = 0; m_drv = 0; m_drv_bad = 0;
    m_lane_bad = 0; m_rsp = 0; m_pins = 0; m_data = '0;
    for (int i = 0; i < 40; i++) begin
      if (!mem_ce_n) m_ce++;
      if (!mem_oe_n) m_oe++;
      if (!mem_we_n) m_we++;
      if (mem_dq_oe) begin
        m_drv++;
        if (mem_we_n || mem_dq_out != m_wdata) m_drv_bad++;
      end
      if (!mem_ce_n && mem_lane_n != ~m_mask) m_lane_bad++;
      if (mem_ce_n && mem_lane_n != 2'b11) m_lane_bad++;
      if (rsp_valid) begin m_rsp++; m_data = rsp_rdata; end
      if (pins() != snap) m_pins++;
      if (req_ready) break;
      m_busy++;
      @(negedge clk);
    end
  endtask

  task automatic access(input bit wr, input int a, input logic [15:0] d, input logic [1:0] mk);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    snap = pins();
    req_valid = 1'b1; req_write = wr; req_addr = 18'(a); req_wdata = d; req_mask = mk;
    m_wdata = d; m_mask = mk;
    @(negedge clk);
    req_valid = 1'b0;
    monitor();
    if (wr && mk != 2'b00) begin
      automatic logic [15:0] s = rd_shadow(a);
      if (mk[0]) s[7:0]  = d[7:0];
      if (mk[1]) s[15:8] = d[15:8];
      shadow[a] = s;
    end
  endtask

  function automatic logic [15:0] masked(input logic [15:0] v, input logic [1:0] mk);
    return {mk[1] ? v[15:8] : 8'h00, mk[0] ? v[7:0] : 8'h00};
  endfunction

  task automatic check_read(input int a, input logic [1:0] mk, input string tag);
    access(1'b0, a, 16'h0, mk);
    chk(m_rsp == 1, "R9", {tag, " one response"}, m_rsp, 1);
    chk(m_data == masked(rd_shadow(a), mk), "R3", {tag, " read data"}, m_data, masked(rd_shadow(a), mk));
    chk(m_ce == RD_N && m_oe == RD_N && m_we == 0, "R3", {tag, " read strobes"}, m_ce, RD_N);
    chk(m_lane_bad == 0, "R10", {tag, " lane enables"}, m_lane_bad, 0);
  endtask

  task automatic check_write(input int a, input logic [15:0] d, input logic [1:0] mk, input string tag);
    access(1'b1, a, d, mk);
    chk(m_we == WR_N && m_ce == WR_N && m_oe == WR_N, "R4", {tag, " write pulse"}, m_we, WR_N);
    chk(m_drv == DRV_N && m_drv_bad == 0, "R5", {tag, " drive window"}, m_drv, DRV_N);
    chk(m_rsp == 0, "R9", {tag, " no response on write"}, m_rsp, 0);
    chk(m_lane_bad == 0, "R10", {tag, " lane enables"}, m_lane_bad, 0);
    chk(m_busy == BUSY_N, "R8", {tag, " busy span"}, m_busy, BUSY_N);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(req_ready && !rsp_valid && !mem_dq_oe && mem_ce_n && mem_oe_n && mem_we_n && mem_lane_n == 2'b11,
        "R1", "idle pins under reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe}, 6'b111110);
  endtask

  task automatic t_full_word();
    check_write(18'h00101, 16'h1234, 2'b11, "full write");
    check_read(18'h00101, 2'b11, "full read");
  endtask

  task automatic t_byte_lanes();
    check_write(18'h00101, 16'hABCD, 2'b01, "low lane write");
    check_read(18'h00101, 2'b11, "after low write");
    chk(m_data == 16'h12CD, "R4", "high lane kept", m_data, 16'h12CD);
    check_write(18'h00101, 16'h5600, 2'b10, "high lane write");
    check_read(18'h00101, 2'b11, "after high write");
    chk(m_data == 16'h56CD, "R10", "lanes independent", m_data, 16'h56CD);
    check_read(18'h00101, 2'b01, "low lane read");
    chk(m_data == 16'h00CD, "R3", "disabled lane zero", m_data, 16'h00CD);
  endtask

  task automatic t_null_write();
    access(1'b1, 18'h00101, 16'hFFFF, 2'b00);
    chk(m_pins == 0 && m_busy == 0, "R7", "null write quiet", m_pins, 0);
    check_read(18'h00101, 2'b11, "after null write");
    chk(m_data == 16'h56CD, "R7", "null write stored nothing", m_data, 16'h56CD);
  endtask

  task automatic t_null_read_overlap();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00101; req_mask = 2'b00;
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == 16'h0 && req_ready && mem_ce_n, "R7", "null read response",
        {rsp_valid, rsp_rdata}, {1'b1, 16'h0});
    snap = pins();
    req_write = 1'b1; req_addr = 18'h00200; req_wdata = 16'h7788; req_mask = 2'b11;
    m_wdata = 16'h7788; m_mask = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    monitor();
    shadow[18'h00200] = 16'h7788;
    chk(m_we == WR_N && m_drv == DRV_N, "R4", "write in response cycle", m_we, WR_N);
    check_read(18'h00200, 2'b11, "overlap readback");
  endtask

  task automatic t_busy_ignored();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00300; req_wdata = 16'h2468; req_mask = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 18'h00301; req_wdata = 16'hBEEF;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    shadow[18'h00300] = 16'h2468;
    check_read(18'h00301, 2'b11, "busy request");
    chk(m_data == 16'h0000, "R8", "request under busy ignored", m_data, 16'h0000);
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 4; i++)
      check_write(18'h3FFF0 + i, 16'(16'h1111 * (i + 1)), 2'b11, "burst write");
    for (int i = 0; i < 4; i++)
      check_read(18'h3FFF0 + i, 2'b11, "burst read");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_word();
    t_byte_lanes();
    t_null_write();
    t_null_read_overlap();
    t_busy_ignored();
    t_back_to_back();
    chk(addr_viol == 0, "R2", "address moved under active strobe", addr_viol, 0);
    chk(gap_viol == 0, "R6", "missing idle cycle", gap_viol, 0);
    chk(clash == 0, "R5", "bus driven from both sides", clash, 0);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    summary();
  end

endmodule